// File: doc/BRIEF.md
# Shift-Scaled Parametric Equalizer Band

This block is one band of a mixing-console style equalizer. Each incoming 24-bit sample goes straight into a second-order recursive filter (biquad) whose five coefficients are supplied on ports. A parallel copy of the same sample is scaled down by a two-bit arithmetic right shift. The filter output is multiplied by a signed fractional lift/cut gain and added to that shifted copy. The total is then shifted back up by two bits and clamped to the 24-bit signed range.

Shifting the dry signal down and the total back up gives the filtered part four times more weight in the output than the gain word alone could give. With a filter that passes a band at unity, a gain near +1.0 lifts that band by roughly 14 dB. That covers the usual ±12 dB knob range. Cut is obtained with negative gain. The coefficients and gain come from an outside controller, which computes them from frequency, Q and level. The filter history moves forward only on samples marked valid, so the band can sit in a sample-rate pipeline that has idle cycles.

Top module: `peq_band`

## Requirements
- R1: The filter computes acc = b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. All coefficients are signed 24-bit with 22 fractional bits, so 24'h400000 is 1.0 and 24'hE00000 is −0.5. The filter output is y[n] = acc arithmetically shifted right by 22 and clamped to [−8388608, 8388607]. This clamped value is also what is fed back.
- R2: The dry path is the input sample arithmetically shifted right by two bits, with the sign bit extended. It is delayed so that it meets the filter output of the same sample.
- R3: The wet term is (gain · y[n]) arithmetically shifted right by 23. Gain is signed 24-bit with 23 fractional bits, so 24'h7FFFFF is just below +1.0.
- R4: The output is (dry + wet) multiplied by four. This is formed at a width wide enough not to overflow, then clamped to [−8388608, 8388607].
- R5: With gain equal to zero, the output equals the input sample with its two least significant bits cleared. Negative samples round toward minus infinity (−5 gives −8).
- R6: out_valid is high exactly two clock cycles after each cycle with in_valid high. Samples presented on consecutive cycles give results on consecutive cycles.
- R7: Cycles with in_valid low do not advance the filter history. During them out_sample holds its last value and out_valid stays low.
- R8: An active-low asynchronous reset clears the filter history, out_valid and out_sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks a valid input sample |
| in_sample | input | 24 | Signed input sample |
| coef_b0 | input | 24 | Feed-forward coefficient, current sample |
| coef_b1 | input | 24 | Feed-forward coefficient, one sample back |
| coef_b2 | input | 24 | Feed-forward coefficient, two samples back |
| coef_a1 | input | 24 | Feedback coefficient, one output back |
| coef_a2 | input | 24 | Feedback coefficient, two outputs back |
| gain | input | 24 | Signed fractional lift/cut gain |
| out_valid | output | 1 | Marks a valid output sample |
| out_sample | output | 24 | Signed, clamped output sample |

## Verification
The hardest condition to reach from the ports is the recursive history lining up correctly when valid samples are separated by idle cycles. A slip of the history on a non-valid cycle only shows up several samples later, through the delayed taps. The bench sets a filter whose only nonzero tap is the two-sample-back coefficient, or one with feedback of −0.5. It then feeds impulses and short sequences, both back to back and with idle gaps. Every output is compared with a sample-accurate model, and out_sample is watched for stability during the gaps. Clamping on both rails is reached by combining near-full gain with inputs above three eighths of full scale, positive and negative.

// File: rtl/peq_band.sv
module peq_band #(
  parameter int DW    = 24,
  parameter int CFRAC = 22,
  parameter int GFRAC = 23,
  parameter int SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic signed [DW-1:0] coef_b0,
  input  logic signed [DW-1:0] coef_b1,
  input  logic signed [DW-1:0] coef_b2,
  input  logic signed [DW-1:0] coef_a1,
  input  logic signed [DW-1:0] coef_a2,
  input  logic signed [DW-1:0] gain,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  localparam int AW = 2*DW + 4;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [AW-1:0] MAXA = AW'(MAXV);
  localparam logic signed [AW-1:0] MINA = AW'(MINV);

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > MAXA)      return MAXV;
    else if (v < MINA) return MINV;
    else               return v[DW-1:0];
  endfunction

  logic signed [DW-1:0] x1, x2, y1, y2, wet_y, dry_q;
  logic                 stage_v;
  logic signed [AW-1:0] acc, wet, total;
  logic signed [DW-1:0] y_new;

  assign acc = AW'(coef_b0) * AW'(in_sample)
             + AW'(coef_b1) * AW'(x1)
             + AW'(coef_b2) * AW'(x2)
             - AW'(coef_a1) * AW'(y1)
             - AW'(coef_a2) * AW'(y2);
  assign y_new = clamp(acc >>> CFRAC);

  assign wet   = (AW'(gain) * AW'(wet_y)) >>> GFRAC;
  assign total = (AW'(dry_q) + wet) <<< SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
      wet_y <= '0; dry_q <= '0; stage_v <= 1'b0;
    end else begin
      stage_v <= in_valid;
      if (in_valid) begin
        x1    <= in_sample;
        x2    <= x1;
        y1    <= y_new;
        y2    <= y1;
        wet_y <= y_new;
        dry_q <= in_sample >>> SHIFT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= stage_v;
      if (stage_v) out_sample <= clamp(total);
    end
  end
endmodule

module peq_band_chk #(
  parameter int DW    = 24,
  parameter int SHIFT = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_sample,
  input logic signed [DW-1:0] gain,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample
);
  logic v_a, v_b;
  logic signed [DW-1:0] in_a, in_b, g_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_a <= 1'b0; v_b <= 1'b0;
      in_a <= '0; in_b <= '0; g_a <= '0;
    end else begin
      v_a <= in_valid; v_b <= v_a;
      in_a <= in_sample; in_b <= in_a;
      g_a <= gain;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_b); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample)); // R7
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && g_a == '0) |-> out_sample == ((in_b >>> SHIFT) <<< SHIFT)); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && out_sample == '0)); // R8
endmodule

bind peq_band peq_band_chk #(.DW(DW), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .gain(gain), .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/peq_band_bench.sv
`timescale 1ns/1ps
module peq_band_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [23:0] in_sample = '0;
  logic signed [23:0] coef_b0 = '0, coef_b1 = '0, coef_b2 = '0, coef_a1 = '0, coef_a2 = '0;
  logic signed [23:0] gain = '0;
  logic out_valid;
  logic signed [23:0] out_sample;

  always #10 clk = ~clk;

  peq_band u_peq_band (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_b0(coef_b0), .coef_b1(coef_b1), .coef_b2(coef_b2),
    .coef_a1(coef_a1), .coef_a2(coef_a2), .gain(gain),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  int n_run = 0, n_fail = 0;
  longint c0, c1, c2, ca1, ca2, g;
  longint hx1, hx2, hy1, hy2;
  longint xs[16];
  longint ex[16];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat24(input longint v);
    if (v > 64'sd8388607) return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint model(input longint x);
    longint acc, y, d, p;
    acc = c0*x + c1*hx1 + c2*hx2 - ca1*hy1 - ca2*hy2;
    y = sat24(acc >>> 22);
    hx2 = hx1; hx1 = x; hy2 = hy1; hy1 = y;
    d = x >>> 2;
    p = (g*y) >>> 23;
    return sat24((d + p) * 4);
  endfunction

  task automatic setup(input longint b0, input longint b1, input longint b2,
                       input longint a1, input longint a2, input longint gg);
    c0 = b0; c1 = b1; c2 = b2; ca1 = a1; ca2 = a2; g = gg;
    @(negedge clk);
    coef_b0 = 24'(b0); coef_b1 = 24'(b1); coef_b2 = 24'(b2);
    coef_a1 = 24'(a1); coef_a2 = 24'(a2); gain = 24'(gg);
    rst_n = 1'b0; in_valid = 1'b0;
    hx1 = 0; hx2 = 0; hy1 = 0; hy2 = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic stream(input int n, input string req);
    for (int i = 0; i < n; i++) ex[i] = model(xs[i]);
    for (int i = 0; i < n + 2; i++) begin
      if (i >= 2) begin
        check(out_valid === 1'b1, "R6", longint'(out_valid), 1);
        check(longint'(out_sample) == ex[i-2], req, longint'(out_sample), ex[i-2]);
      end
      in_valid = (i < n);
      in_sample = (i < n) ? 24'(xs[i]) : '0;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic gapped(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      longint e;
      e = model(xs[i]);
      in_valid = 1'b1; in_sample = 24'(xs[i]);
      @(negedge clk);
      in_valid = 1'b0; in_sample = 24'h5A5A5A;
      @(negedge clk);
      check(out_valid === 1'b1, "R6", longint'(out_valid), 1);
      check(longint'(out_sample) == e, req, longint'(out_sample), e);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(out_valid === 1'b0, "R7", longint'(out_valid), 0);
        check(longint'(out_sample) == e, "R7", longint'(out_sample), e);
      end
    end
  endtask

  task automatic t_reset;
    setup(64'sh400000, 0, 0, 0, 0, 0);
    check(out_valid === 1'b0, "R8", longint'(out_valid), 0);
    check(out_sample === '0, "R8", longint'(out_sample), 0);
    xs[0] = 1000; stream(1, "R8");
    rst_n = 1'b0; #1;
    check(out_sample === '0 && out_valid === 1'b0, "R8", longint'(out_sample), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_zero_gain;
    longint v[4] = '{1237, -5, 8388607, -8388608};
    setup(64'sh400000, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) xs[i] = v[i];
    for (int i = 0; i < 4; i++) ex[i] = v[i] & ~64'sd3;
    for (int i = 0; i < 6; i++) begin
      if (i >= 2) check(longint'(out_sample) == ex[i-2], "R5 R2", longint'(out_sample), ex[i-2]);
      in_valid = (i < 4);
      in_sample = (i < 4) ? 24'(xs[i]) : '0;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_boost;
    setup(64'sh400000, 0, 0, 0, 0, 64'sh7FFFFF);
    xs[0] = 100000; xs[1] = -100000; xs[2] = 64'sh300000; xs[3] = -64'sh300000;
    stream(4, "R3 R4");
    check(ex[2] == 8388607 && ex[3] == -8388608, "R4", ex[2], 8388607);
    setup(64'sh400000, 0, 0, 0, 0, -64'sh200000);
    xs[0] = 400000; xs[1] = -77777;
    stream(2, "R3");
  endtask

  task automatic t_recursion;
    setup(64'sh400000, 0, 0, -64'sh200000, 0, 64'sh200000);
    xs[0] = 64'sh100000;
    for (int i = 1; i < 8; i++) xs[i] = 0;
    stream(8, "R1");
    setup(64'sh200000, 64'sh200000, 0, -64'sh600000, 64'sh380000, 64'sh400000);
    for (int i = 0; i < 10; i++) xs[i] = (i % 3 == 0) ? 64'sh300000 : -64'sh180000;
    stream(10, "R1");
  endtask

  task automatic t_taps_gaps;
    setup(0, 0, 64'sh400000, 0, 0, 64'sh200000);
    xs[0] = 50000; xs[1] = -30000; xs[2] = 7; xs[3] = 123456; xs[4] = 0;
    gapped(5, "R7 R1");
    setup(64'sh400000, 0, 0, -64'sh200000, 0, 64'sh400000);
    xs[0] = 64'sh80000; xs[1] = 0; xs[2] = 0; xs[3] = -64'sh40000;
    gapped(4, "R7 R1");
  endtask

  initial begin
    t_reset();
    t_zero_gain();
    t_boost();
    t_recursion();
    t_taps_gaps();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule